// File: doc/BRIEF.md
# Three-Cell Pack Protection Controller

This block decides, on every clock, whether the charge switch and the discharge switch of a three-cell series lithium pack may be closed. It never sees analog voltages. Every cell delivers four ready-made comparator flags:
- the cell is above the level that starts overcharge;
- the cell is at or below the level that ends overcharge;
- the cell is below the level that starts overdischarge;
- the cell is at or above the level that ends overdischarge.

The load side delivers its own flags:
- the sense node is at or past overcurrent level 1;
- the charger voltage has been seen;
- the charger is above the zero-volt charge start threshold;
- an already qualified overcurrent event is present.

A strap enables zero-volt charging. A control input, plus a flag that says the control pin is open, can inhibit the pack.

An overcharge condition must hold for a programmable number of clock ticks before it is accepted. An overdischarge condition is qualified the same way, with its own count. After an overcharge is accepted, the block marks which cells are high and drives one conditioning output per marked cell, so that an external bleed path can run. Overcharge ends in one of two ways:
- every marked cell has fallen back to its release level;
- a discharge is seen through the charge switch's body diode, which shows up as the load sense reaching overcurrent level 1.

An accepted overdischarge opens the discharge switch and latches the block into power-down. Only a charger sighting ends power-down. The overdischarge state itself ends later, once every cell is back at its release level.

Overcharge and overdischarge are tracked independently, so the two can be active at the same time.

Top module: `pack_guard`

## Requirements
- R1: After reset, once no state flag is set and no inhibit, overcurrent or zero-volt condition is present, `chg_en` and `dsg_en` are both 1 one clock after the inputs settle, and `cond` is 000.
- R2: When any bit of `cell_hi` is 1 on OVC_DLY consecutive clock edges, `st_ovc` becomes 1 at the last of those edges and `chg_en` becomes 0 one edge later.
- R3: While `st_ovc` is 1, bit i of `cond` is 1 for every cell i that has shown `cell_hi[i]` since overcharge was accepted. The bit stays 1 until `cell_rel[i]` is 1. When no marked cell remains, overcharge ends. `cond` is 000 whenever `st_ovc` is 0.
- R4: While `st_ovc` is 1, a single edge with `load_oc1` = 1 clears `st_ovc` and `cond`, even when the marked cells are not at their release level.
- R5: When any bit of `cell_lo` is 1 on ODC_DLY consecutive edges, `st_odc` and `st_pdn` become 1 at the last of those edges and `dsg_en` becomes 0 one edge later. `chg_en` is not affected.
- R6: `st_pdn` stays 1 until an edge with `charger_seen` = 1. `st_odc` clears only on an edge where `st_pdn` is already 0 and all bits of `cell_ok` are 1.
- R7: The effective inhibit is `ctl_inh` OR (`ctl_open` AND NOT `st_pdn`). While it is 1, both enables are 0 one edge later. Detection keeps running during inhibit, so enables re-evaluated after release reflect any state accepted meanwhile.
- R8: Overcharge and overdischarge can be held together, with both enables 0. Clearing overcharge through `load_oc1` leaves `st_odc` set.
- R9: When `zv_opt` and `zv_start` are both 1 and the effective inhibit is 0, `chg_en` is 1 and `dsg_en` is 0 one edge later, whatever the state flags. With `zv_opt` = 0, `zv_start` has no effect.
- R10: If the qualifying condition drops for one edge before its count completes, the count restarts from zero.
- R11: `oc_det` = 1 without the zero-volt condition makes both enables 0 one edge later.
- R12: Synchronous `rst` clears all state flags, `cond` and both enables at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cell_hi | input | NCELL | Cell above overcharge-detect level |
| cell_rel | input | NCELL | Cell at or below overcharge-release level |
| cell_lo | input | NCELL | Cell below overdischarge-detect level |
| cell_ok | input | NCELL | Cell at or above overdischarge-release level |
| load_oc1 | input | 1 | Load sense at or past overcurrent level 1 |
| charger_seen | input | 1 | Load-side voltage at the charger (level 3) threshold |
| zv_start | input | 1 | Charger at or above zero-volt start threshold |
| zv_opt | input | 1 | Zero-volt charging option strap |
| oc_det | input | 1 | Qualified overcurrent status |
| ctl_inh | input | 1 | Control inhibit, active high |
| ctl_open | input | 1 | Control pin floating |
| chg_en | output | 1 | Charge switch enable |
| dsg_en | output | 1 | Discharge switch enable |
| cond | output | NCELL | Per-cell conditioning outputs |
| st_ovc | output | 1 | Overcharge state |
| st_odc | output | 1 | Overdischarge state |
| st_pdn | output | 1 | Power-down state |

## Verification
The assertions watch the following every cycle:
- the gating of the enables by each state flag, by inhibit, by overcurrent and by the zero-volt override;
- that `cond` is idle outside overcharge;
- that power-down implies overdischarge;
- that power-down persists without a charger;
- that the load sense releases overcharge.

Some behaviour only the bench scenarios can show:
- the exact qualification lengths and the count restart after a lapse;
- the per-cell marking and per-cell release for every cell pattern;
- the ordering of power-down exit before overdischarge exit;
- states accepted while inhibited.

// File: rtl/pg_pkg.sv
package pg_pkg;
  typedef struct packed {
    logic ovc;
    logic odc;
    logic pdn;
  } pg_flags_t;

  // returns {charge, discharge}
  function automatic logic [1:0] pg_gate(pg_flags_t f, logic inh, logic oc, logic zv);
    logic [1:0] g;
    if (inh)      g = 2'b00;
    else if (zv)  g = 2'b10;
    else if (oc)  g = 2'b00;
    else          g = {~f.ovc, ~f.odc};
    return g;
  endfunction
endpackage

// File: rtl/pg_qual.sv
module pg_qual #(
  parameter int DLY = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic hold,
  output logic fire
);
  localparam int CW = (DLY > 1) ? $clog2(DLY) : 1;
  localparam logic [CW-1:0] LAST = CW'(DLY - 1);

  logic [CW-1:0] cnt;

  assign fire = arm & ~hold & (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || !arm || hold || fire) cnt <= '0;
    else                             cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/pg_ovc.sv
module pg_ovc #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fire,
  input  logic [N-1:0] cell_hi,
  input  logic [N-1:0] cell_rel,
  input  logic         load_oc1,
  output logic         ovc,
  output logic [N-1:0] mask
);
  logic [N-1:0] mask_n;
  logic         ovc_n;

  always_comb begin
    mask_n = mask;
    ovc_n  = ovc;
    if (ovc) begin
      if (load_oc1) begin
        mask_n = '0;
        ovc_n  = 1'b0;
      end else begin
        mask_n = (mask | cell_hi) & ~cell_rel;
        ovc_n  = |mask_n;
      end
    end else if (fire) begin
      mask_n = cell_hi & ~cell_rel;
      ovc_n  = |mask_n;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ovc  <= 1'b0;
      mask <= '0;
    end else begin
      ovc  <= ovc_n;
      mask <= mask_n;
    end
  end
endmodule

// File: rtl/pg_odc.sv
module pg_odc #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         fire,
  input  logic         charger_seen,
  input  logic [N-1:0] cell_ok,
  output logic         odc,
  output logic         pdn
);
  always_ff @(posedge clk) begin
    if (rst) begin
      odc <= 1'b0;
      pdn <= 1'b0;
    end else if (fire) begin
      odc <= 1'b1;
      pdn <= 1'b1;
    end else begin
      if (pdn && charger_seen) pdn <= 1'b0;
      if (odc && !pdn && (&cell_ok)) odc <= 1'b0;
    end
  end
endmodule

// File: rtl/pack_guard.sv
module pack_guard
  import pg_pkg::*;
#(
  parameter int NCELL   = 3,
  parameter int OVC_DLY = 4,
  parameter int ODC_DLY = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NCELL-1:0] cell_hi,
  input  logic [NCELL-1:0] cell_rel,
  input  logic [NCELL-1:0] cell_lo,
  input  logic [NCELL-1:0] cell_ok,
  input  logic             load_oc1,
  input  logic             charger_seen,
  input  logic             zv_start,
  input  logic             zv_opt,
  input  logic             oc_det,
  input  logic             ctl_inh,
  input  logic             ctl_open,
  output logic             chg_en,
  output logic             dsg_en,
  output logic [NCELL-1:0] cond,
  output logic             st_ovc,
  output logic             st_odc,
  output logic             st_pdn
);
  logic      ovc_fire, odc_fire;
  logic      inh_eff, zv_force;
  logic [1:0] gate;
  pg_flags_t flags;

  pg_qual #(.DLY(OVC_DLY)) u_ovc_q (
    .clk(clk), .rst(rst), .arm(|cell_hi), .hold(st_ovc), .fire(ovc_fire)
  );

  pg_qual #(.DLY(ODC_DLY)) u_odc_q (
    .clk(clk), .rst(rst), .arm(|cell_lo), .hold(st_odc), .fire(odc_fire)
  );

  pg_ovc #(.N(NCELL)) u_ovc (
    .clk(clk), .rst(rst), .fire(ovc_fire), .cell_hi(cell_hi),
    .cell_rel(cell_rel), .load_oc1(load_oc1), .ovc(st_ovc), .mask(cond)
  );

  pg_odc #(.N(NCELL)) u_odc (
    .clk(clk), .rst(rst), .fire(odc_fire), .charger_seen(charger_seen),
    .cell_ok(cell_ok), .odc(st_odc), .pdn(st_pdn)
  );

  assign flags    = '{ovc: st_ovc, odc: st_odc, pdn: st_pdn};
  assign inh_eff  = ctl_inh | (ctl_open & ~st_pdn);
  assign zv_force = zv_opt & zv_start;
  assign gate     = pg_gate(flags, inh_eff, oc_det, zv_force);

  always_ff @(posedge clk) begin
    if (rst) begin
      chg_en <= 1'b0;
      dsg_en <= 1'b0;
    end else begin
      chg_en <= gate[1];
      dsg_en <= gate[0];
    end
  end
endmodule

// File: rtl/pack_guard_chk.sv
module pack_guard_chk #(
  parameter int N = 3
) (
  input logic         clk,
  input logic         rst,
  input logic         load_oc1,
  input logic         charger_seen,
  input logic         zv_start,
  input logic         zv_opt,
  input logic         oc_det,
  input logic         ctl_inh,
  input logic         ctl_open,
  input logic         chg_en,
  input logic         dsg_en,
  input logic [N-1:0] cond,
  input logic         st_ovc,
  input logic         st_odc,
  input logic         st_pdn
);
  a_r2_ovc_blocks_charge: assert property (@(posedge clk) disable iff (rst)
    (st_ovc && !(zv_opt && zv_start)) |=> !chg_en);

  a_r3_cond_idle: assert property (@(posedge clk) disable iff (rst)
    !st_ovc |-> (cond == '0));

  a_r4_load_release: assert property (@(posedge clk) disable iff (rst)
    (st_ovc && load_oc1) |=> !st_ovc);

  a_r5_odc_blocks_discharge: assert property (@(posedge clk) disable iff (rst)
    st_odc |=> !dsg_en);

  a_r6_pdn_needs_odc: assert property (@(posedge clk) disable iff (rst)
    st_pdn |-> st_odc);

  a_r6_pdn_holds: assert property (@(posedge clk) disable iff (rst)
    (st_pdn && !charger_seen) |=> st_pdn);

  a_r7_inhibit: assert property (@(posedge clk) disable iff (rst)
    (ctl_inh || (ctl_open && !st_pdn)) |=> (!chg_en && !dsg_en));

  a_r9_zero_volt: assert property (@(posedge clk) disable iff (rst)
    (zv_opt && zv_start && !ctl_inh && !(ctl_open && !st_pdn)) |=> (chg_en && !dsg_en));

  a_r11_overcurrent: assert property (@(posedge clk) disable iff (rst)
    (oc_det && !(zv_opt && zv_start)) |=> (!chg_en && !dsg_en));
endmodule

bind pack_guard pack_guard_chk #(.N(NCELL)) i_pack_guard_chk (
  .clk(clk), .rst(rst), .load_oc1(load_oc1), .charger_seen(charger_seen),
  .zv_start(zv_start), .zv_opt(zv_opt), .oc_det(oc_det), .ctl_inh(ctl_inh),
  .ctl_open(ctl_open), .chg_en(chg_en), .dsg_en(dsg_en), .cond(cond),
  .st_ovc(st_ovc), .st_odc(st_odc), .st_pdn(st_pdn)
);

// File: tb/test_pack_guard.sv
module test_pack_guard;
  localparam int N  = 3;
  localparam int OD = 4;
  localparam int UD = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [N-1:0] cell_hi = '0, cell_rel = '1, cell_lo = '0, cell_ok = '1;
  logic load_oc1 = 0, charger_seen = 0, zv_start = 0, zv_opt = 0;
  logic oc_det = 0, ctl_inh = 0, ctl_open = 0;
  logic chg_en, dsg_en, st_ovc, st_odc, st_pdn;
  logic [N-1:0] cond;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #2 clk = ~clk;

  pack_guard #(.NCELL(N), .OVC_DLY(OD), .ODC_DLY(UD)) i_pack_guard (
    .clk(clk), .rst(rst), .cell_hi(cell_hi), .cell_rel(cell_rel),
    .cell_lo(cell_lo), .cell_ok(cell_ok), .load_oc1(load_oc1),
    .charger_seen(charger_seen), .zv_start(zv_start), .zv_opt(zv_opt),
    .oc_det(oc_det), .ctl_inh(ctl_inh), .ctl_open(ctl_open),
    .chg_en(chg_en), .dsg_en(dsg_en), .cond(cond),
    .st_ovc(st_ovc), .st_odc(st_odc), .st_pdn(st_pdn)
  );

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic en(input string tag, input logic c, input logic d);
    chk({tag, " chg_en"}, 32'(chg_en), 32'(c));
    chk({tag, " dsg_en"}, 32'(dsg_en), 32'(d));
  endtask

  task automatic finish_up;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(4 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    tick(3);
    // R12 / R1: reset values
    en("R12 in reset", 1'b0, 1'b0);
    chk("R12 cond in reset", 32'(cond), 0);
    chk("R12 flags in reset", 32'({st_ovc, st_odc, st_pdn}), 0);
    rst = 0;
    tick(1);
    en("R1 normal", 1'b1, 1'b1);
    chk("R1 cond normal", 32'(cond), 0);

    // R2: exact overcharge qualification
    cell_hi = 3'b001; cell_rel = 3'b110;
    tick(OD - 1);
    chk("R2 before count", 32'(st_ovc), 0);
    tick(1);
    chk("R2 flag at count", 32'(st_ovc), 1);
    en("R2 charge still on", 1'b1, 1'b1);
    tick(1);
    en("R2 charge off", 1'b0, 1'b1);
    cell_hi = '0; cell_rel = '1;
    tick(2);
    en("R2 recovered", 1'b1, 1'b1);

    // R10: lapse restarts the count
    cell_hi = 3'b010; cell_rel = 3'b101;
    tick(OD - 1);
    cell_hi = '0;
    tick(1);
    cell_hi = 3'b010;
    tick(OD - 1);
    chk("R10 no detect after lapse", 32'(st_ovc), 0);
    tick(1);
    chk("R10 detect after full run", 32'(st_ovc), 1);
    cell_hi = '0; cell_rel = '1;
    tick(3);

    // R3: sweep all cell patterns, per-cell release
    for (int p = 1; p < 8; p++) begin
      logic [N-1:0] pm, low;
      pm  = N'(p);
      low = pm & (~pm + 1'b1);
      cell_hi = pm; cell_rel = ~pm;
      tick(OD + 1);
      chk($sformatf("R3 cond p=%0d", p), 32'(cond), 32'(pm));
      en($sformatf("R3 ovc p=%0d", p), 1'b0, 1'b1);
      cell_hi = '0;
      tick(2);
      chk($sformatf("R3 cond held p=%0d", p), 32'(cond), 32'(pm));
      cell_rel = ~pm | low;
      tick(1);
      chk($sformatf("R3 partial release p=%0d", p), 32'(cond), 32'(pm & ~low));
      chk($sformatf("R3 ovc after partial p=%0d", p), 32'(st_ovc), 32'((pm & ~low) != 0));
      cell_rel = '1;
      tick(2);
      chk($sformatf("R3 cond idle p=%0d", p), 32'(cond), 0);
      en($sformatf("R3 released p=%0d", p), 1'b1, 1'b1);
    end

    // R4: release by discharge through body diode
    cell_hi = 3'b100; cell_rel = 3'b011;
    tick(OD + 1);
    cell_hi = '0; load_oc1 = 1;
    tick(1);
    load_oc1 = 0;
    chk("R4 ovc cleared", 32'(st_ovc), 0);
    chk("R4 cond cleared", 32'(cond), 0);
    tick(1);
    en("R4 charge back", 1'b1, 1'b1);
    cell_rel = '1;
    tick(1);

    // R5: overdischarge qualification and power-down
    cell_lo = 3'b010; cell_ok = 3'b101;
    tick(UD - 1);
    chk("R5 before count", 32'(st_odc), 0);
    tick(1);
    chk("R5 odc+pdn", 32'({st_odc, st_pdn}), 3);
    en("R5 discharge still on", 1'b1, 1'b1);
    tick(1);
    en("R5 discharge off", 1'b1, 1'b0);
    cell_lo = '0;
    tick(2);

    // R6: power-down exit needs charger, odc exit needs all cells
    cell_ok = '1;
    tick(3);
    chk("R6 pdn held without charger", 32'(st_pdn), 1);
    en("R6 still off", 1'b1, 1'b0);
    cell_ok = 3'b101; charger_seen = 1;
    tick(1);
    charger_seen = 0;
    chk("R6 pdn left", 32'(st_pdn), 0);
    chk("R6 odc kept", 32'(st_odc), 1);
    tick(2);
    en("R6 discharge off while cell low", 1'b1, 1'b0);
    cell_ok = '1;
    tick(1);
    chk("R6 odc cleared", 32'(st_odc), 0);
    tick(1);
    en("R6 normal again", 1'b1, 1'b1);

    // R8 + R9: both states together, zero-volt override
    cell_lo = 3'b001; cell_ok = 3'b110;
    tick(UD + 1);
    cell_lo = '0; charger_seen = 1;
    tick(1);
    charger_seen = 0;
    cell_hi = 3'b100; cell_rel = 3'b011;
    tick(OD + 1);
    chk("R8 both flags", 32'({st_ovc, st_odc}), 3);
    en("R8 both off", 1'b0, 1'b0);
    zv_opt = 1; zv_start = 1;
    tick(2);
    en("R9 zero-volt forced", 1'b1, 1'b0);
    zv_opt = 0;
    tick(2);
    en("R9 strap off no effect", 1'b0, 1'b0);
    zv_start = 0;
    cell_hi = '0; load_oc1 = 1;
    tick(1);
    load_oc1 = 0;
    tick(2);
    chk("R8 ovc cleared odc kept", 32'({st_ovc, st_odc}), 1);
    en("R8 charge only", 1'b1, 1'b0);
    cell_ok = '1; cell_rel = '1;
    tick(3);
    en("R8 normal again", 1'b1, 1'b1);

    // R7: inhibit, detection during inhibit, floating pin
    ctl_inh = 1;
    tick(2);
    en("R7 inhibit", 1'b0, 1'b0);
    cell_hi = 3'b001; cell_rel = 3'b110;
    tick(OD + 1);
    ctl_inh = 0;
    tick(2);
    en("R7 reevaluated", 1'b0, 1'b1);
    cell_hi = '0; cell_rel = '1;
    tick(3);
    ctl_open = 1;
    tick(2);
    en("R7 open pin inhibits", 1'b0, 1'b0);
    ctl_open = 0;
    tick(2);
    en("R7 open removed", 1'b1, 1'b1);
    cell_lo = 3'b001; cell_ok = 3'b110;
    tick(UD + 1);
    cell_lo = '0;
    ctl_open = 1;
    tick(2);
    en("R7 open ignored in pdn", 1'b1, 1'b0);
    charger_seen = 1;
    tick(1);
    charger_seen = 0;
    tick(1);
    en("R7 open active after pdn", 1'b0, 1'b0);
    ctl_open = 0; cell_ok = '1;
    tick(3);
    en("R7 clean", 1'b1, 1'b1);

    // R11: qualified overcurrent input
    oc_det = 1;
    tick(1);
    en("R11 overcurrent", 1'b0, 1'b0);
    oc_det = 0;
    tick(1);
    en("R11 overcurrent gone", 1'b1, 1'b1);

    // R12: reset from a busy state
    cell_hi = 3'b011; cell_rel = 3'b100;
    tick(OD + 1);
    rst = 1;
    tick(1);
    chk("R12 reset flags", 32'({st_ovc, st_odc, st_pdn}), 0);
    chk("R12 reset cond", 32'(cond), 0);
    en("R12 reset enables", 1'b0, 1'b0);
    cell_hi = '0; cell_rel = '1;
    rst = 0;
    tick(2);
    en("R1 after reset", 1'b1, 1'b1);

    finish_up();
  end
endmodule